// File: doc/BRIEF.md
# Bit-Addressable RAM Manipulation Unit

This unit carries out single-bit instructions for a small 8-bit microcontroller core. The internal data RAM of 128 bytes holds a window of 16 bytes, starting at byte 0x20, whose 128 bits can each be reached by a 7-bit bit number. The unit receives a bit number and an operation code together with a one-cycle `start`. It splits the bit number into a byte offset and a bit index, adds the window base, and reads the byte through a synchronous RAM port. It then either folds the selected bit into the carry flag or writes the byte back with only that bit changed.

The carry flag is held inside the unit and is visible on `cy`. Three operations act on the carry alone and do not touch the RAM. Each request runs through a fixed sequence of states, so every operation class has a known cycle count. `done` pulses once at the end of every accepted request, and `err` flags requests that the unit rejects.

Top module: `bitop_unit`

## Requirements
- R1: A request on bit number b (0x00..0x7F) reads exactly one RAM byte, at address 0x20 + floor(b/8), and uses bit index b mod 8 of that byte. Every RAM access falls inside 0x20..0x2F. The RAM returns read data one cycle after the cycle in which `ram_rd_en` is high.
- R2: Operation codes on `op`: 0 carry AND bit, 1 carry OR bit, 2 carry XOR bit, 3 copy bit into carry, 4 copy carry into bit, 5 invert bit, 6 set bit, 7 clear bit, 8 invert carry, 9 set carry, 10 clear carry. Codes 11..15 are unassigned. The unit never reads and writes the RAM in the same cycle.
- R3: Code 0 leaves the carry equal to its old value AND the addressed bit.
- R4: Code 1 leaves the carry equal to the old carry OR the bit. Code 2 leaves it equal to the old carry XOR the bit.
- R5: Code 3 loads the addressed bit into the carry. Codes 0..3 never write the RAM.
- R6: Codes 4..7 write the fetched byte back with only the indexed bit replaced: by the carry for code 4, by its inverse for code 5, by 1 for code 6, by 0 for code 7. The carry is left unchanged.
- R7: Codes 8, 9 and 10 invert, set and clear the carry. They make no RAM access and ignore the bit number.
- R8: Let the rising edge that accepts `start` be followed by cycle 1. For codes 0..7, `done` is high in cycle 9. For codes 8..10, `done` is high in cycle 4.
- R9: `done` is high for exactly one cycle per accepted request.
- R10: A request for codes 0..7 with `bit_addr` above 0x7F, or a request with a code from 11..15, is rejected. `done` and `err` are both high in cycle 3, there is no RAM access, and the carry is unchanged.
- R11: A `start` while a request is in progress is ignored. It produces no `done` and no RAM change.
- R12: After a synchronous reset, `cy`, `done`, `err`, `ram_rd_en` and `ram_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted only while idle |
| op | input | 4 | Operation code |
| bit_addr | input | 8 | Bit number; bit 7 set marks it as out of range |
| ram_addr | output | 7 | RAM byte address for a read or a write |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_rdata | input | 8 | RAM read data, valid one cycle after the read strobe |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| cy | output | 1 | Carry flag |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejection flag, high together with done |

## Verification
The assertions check several properties on every cycle: RAM accesses stay inside the 16-byte window, a read and a write never share a cycle, and a write-back differs from the fetched byte in at most one bit. They also check that read-type codes never write, that `done` never lasts two cycles, that `err` only comes with `done`, that a rejected request leaves the carry alone, and that the latched request holds while busy. Only the bench's scenarios can show the rest. That covers the logical result of every code on every one of the 128 bit numbers, the exact latency of each operation class, the mapping from bit number to byte and index, the reset values, and that an overlapping request really leaves the RAM untouched.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [3:0] {
    OP_AND_C   = 4'd0,
    OP_OR_C    = 4'd1,
    OP_XOR_C   = 4'd2,
    OP_LOAD_C  = 4'd3,
    OP_STORE_C = 4'd4,
    OP_CPL_B   = 4'd5,
    OP_SET_B   = 4'd6,
    OP_CLR_B   = 4'd7,
    OP_CPL_C   = 4'd8,
    OP_SET_C   = 4'd9,
    OP_CLR_C   = 4'd10
  } bop_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LAT, ST_DIV, ST_OFS, ST_RD, ST_EXT, ST_UPD, ST_WR, ST_FIN, ST_CY
  } st_e;

  function automatic logic op_known(input logic [3:0] o);
    return o <= 4'd10;
  endfunction

  function automatic logic op_reads(input logic [3:0] o);
    return o inside {OP_AND_C, OP_OR_C, OP_XOR_C, OP_LOAD_C};
  endfunction

  function automatic logic op_writes(input logic [3:0] o);
    return o inside {OP_STORE_C, OP_CPL_B, OP_SET_B, OP_CLR_B};
  endfunction

  function automatic logic op_carry(input logic [3:0] o);
    return o inside {OP_CPL_C, OP_SET_C, OP_CLR_C};
  endfunction

endpackage

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IW = $clog2(DATA_W)
) (
  input  logic [3:0]        op,
  input  logic              cy_in,
  input  logic              sel,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [IW-1:0]     idx,
  output logic              cy_next,
  output logic [DATA_W-1:0] byte_next
);

  logic new_bit;

  always_comb begin
    case (op)
      OP_AND_C:  cy_next = cy_in & sel;
      OP_OR_C:   cy_next = cy_in | sel;
      OP_XOR_C:  cy_next = cy_in ^ sel;
      OP_LOAD_C: cy_next = sel;
      OP_CPL_C:  cy_next = ~cy_in;
      OP_SET_C:  cy_next = 1'b1;
      OP_CLR_C:  cy_next = 1'b0;
      default:   cy_next = cy_in;
    endcase
  end

  always_comb begin
    case (op)
      OP_STORE_C: new_bit = cy_in;
      OP_CPL_B:   new_bit = ~sel;
      OP_SET_B:   new_bit = 1'b1;
      OP_CLR_B:   new_bit = 1'b0;
      default:    new_bit = sel;
    endcase
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign byte_next[g] = (idx == IW'(g)) ? new_bit : byte_in[g];
  end

endmodule

// File: rtl/bitop_fsm.sv
module bitop_fsm
  import bitop_pkg::*;
#(
  parameter int BIT_AW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [3:0]      op_in,
  input  logic [BIT_AW:0] bit_in,
  output st_e             state,
  output logic [3:0]      op_q,
  output logic [BIT_AW:0] bit_q,
  output logic            done,
  output logic            err
);

  logic err_pend;
  logic bad_req;

  always_comb bad_req = !op_known(op_q) || (!op_carry(op_q) && bit_q[BIT_AW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= '0;
      bit_q    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_pend <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_q     <= op_in;
          bit_q    <= bit_in;
          err_pend <= 1'b0;
          state    <= ST_LAT;
        end
        ST_LAT: begin
          if (bad_req) begin
            err_pend <= 1'b1;
            state    <= ST_FIN;
          end else if (op_carry(op_q)) begin
            state <= ST_CY;
          end else begin
            state <= ST_DIV;
          end
        end
        ST_DIV: state <= ST_OFS;
        ST_OFS: state <= ST_RD;
        ST_RD:  state <= ST_EXT;
        ST_EXT: state <= ST_UPD;
        ST_UPD: state <= ST_WR;
        ST_WR:  state <= ST_FIN;
        ST_CY:  state <= ST_FIN;
        ST_FIN: begin
          done  <= 1'b1;
          err   <= err_pend;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_err_needs_done_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  p_busy_holds_request_r11: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> ($stable(op_q) && $stable(bit_q)));

endmodule

// File: rtl/bitop_path.sv
module bitop_path
  import bitop_pkg::*;
#(
  parameter int BIT_AW    = 7,
  parameter int DATA_W    = 8,
  parameter int RAM_AW    = 7,
  parameter int BASE_ADDR = 32,
  localparam int IW     = $clog2(DATA_W),
  localparam int QW     = BIT_AW - IW,
  localparam int REGION = (2 ** BIT_AW) / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  st_e               state,
  input  logic [3:0]        op,
  input  logic [BIT_AW:0]   bit_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              cy
);

  localparam logic [RAM_AW-1:0] WIN_LO = RAM_AW'(BASE_ADDR);
  localparam logic [RAM_AW-1:0] WIN_HI = RAM_AW'(BASE_ADDR + REGION - 1);

  logic [QW-1:0]     quot_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] byte_q;
  logic              sel_q;
  logic              cy_next;
  logic [DATA_W-1:0] byte_next;

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .op        (op),
    .cy_in     (cy),
    .sel       (sel_q),
    .byte_in   (byte_q),
    .idx       (idx_q),
    .cy_next   (cy_next),
    .byte_next (byte_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quot_q    <= '0;
      idx_q     <= '0;
      byte_q    <= '0;
      sel_q     <= 1'b0;
      ram_addr  <= '0;
      ram_rd_en <= 1'b0;
      ram_wr_en <= 1'b0;
      ram_wdata <= '0;
      cy        <= 1'b0;
    end else begin
      case (state)
        ST_DIV: begin
          quot_q <= QW'(bit_addr[BIT_AW-1:0] / DATA_W);
          idx_q  <= IW'(bit_addr[BIT_AW-1:0] % DATA_W);
        end
        ST_OFS: begin
          ram_addr  <= WIN_LO + RAM_AW'(quot_q);
          ram_rd_en <= 1'b1;
        end
        ST_RD: ram_rd_en <= 1'b0;
        ST_EXT: begin
          byte_q <= ram_rdata;
          sel_q  <= ram_rdata[idx_q];
        end
        ST_UPD: begin
          if (op_writes(op)) begin
            ram_wdata <= byte_next;
            ram_wr_en <= 1'b1;
          end else begin
            cy <= cy_next;
          end
        end
        ST_WR: ram_wr_en <= 1'b0;
        ST_CY: cy <= cy_next;
        default: ;
      endcase
    end
  end

  p_ram_window_r1: assert property (@(posedge clk) disable iff (rst)
    (ram_rd_en || ram_wr_en) |-> (ram_addr >= WIN_LO && ram_addr <= WIN_HI));

  p_no_rd_wr_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(ram_rd_en && ram_wr_en));

  p_read_ops_never_write_r5: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> op_writes(op));

  p_single_bit_write_r6: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> ($countones(ram_wdata ^ byte_q) <= 1));

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int BIT_AW    = 7,
  parameter int DATA_W    = 8,
  parameter int RAM_AW    = 7,
  parameter int BASE_ADDR = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [BIT_AW:0]   bit_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_rd_en,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_wr_en,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              cy,
  output logic              done,
  output logic              err
);

  st_e             state;
  logic [3:0]      op_q;
  logic [BIT_AW:0] bit_q;

  bitop_fsm #(.BIT_AW(BIT_AW)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_in  (op),
    .bit_in (bit_addr),
    .state  (state),
    .op_q   (op_q),
    .bit_q  (bit_q),
    .done   (done),
    .err    (err)
  );

  bitop_path #(
    .BIT_AW    (BIT_AW),
    .DATA_W    (DATA_W),
    .RAM_AW    (RAM_AW),
    .BASE_ADDR (BASE_ADDR)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .op        (op_q),
    .bit_addr  (bit_q),
    .ram_rdata (ram_rdata),
    .ram_addr  (ram_addr),
    .ram_rd_en (ram_rd_en),
    .ram_wr_en (ram_wr_en),
    .ram_wdata (ram_wdata),
    .cy        (cy)
  );

  p_reject_keeps_carry_r10: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (cy == $past(cy, 2)));

endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;

  localparam int C_AND = 0, C_OR = 1, C_XOR = 2, C_LOAD = 3, C_STORE = 4;
  localparam int C_CPLB = 5, C_SETB = 6, C_CLRB = 7, C_CPLC = 8, C_SETC = 9, C_CLRC = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [3:0] op_i;
  logic [7:0] bit_i;
  logic [6:0] ram_addr;
  logic       ram_rd_en;
  logic [7:0] ram_rdata;
  logic       ram_wr_en;
  logic [7:0] ram_wdata;
  logic       cy;
  logic       done;
  logic       err;

  logic [7:0] mem     [0:127];
  logic [7:0] exp_mem [0:127];
  logic       exp_cy;
  int         n_checks = 0;
  int         n_fail = 0;
  int         rd_cnt = 0;
  int         wr_cnt = 0;
  int         rd_last = 0;

  always #2 clk = ~clk;

  bitop_unit u_dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op_i),
    .bit_addr  (bit_i),
    .ram_addr  (ram_addr),
    .ram_rd_en (ram_rd_en),
    .ram_rdata (ram_rdata),
    .ram_wr_en (ram_wr_en),
    .ram_wdata (ram_wdata),
    .cy        (cy),
    .done      (done),
    .err       (err)
  );

  function automatic logic [7:0] pat(input int j);
    return 8'((j * 37 + 11) ^ (j >> 2));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < 128; j++) mem[j] <= pat(j);
      ram_rdata <= 8'h00;
    end else begin
      if (ram_wr_en) mem[ram_addr] <= ram_wdata;
      if (ram_rd_en) ram_rdata <= mem[ram_addr];
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (ram_rd_en) begin
        rd_cnt++;
        rd_last = int'(ram_addr);
      end
      if (ram_wr_en) wr_cnt++;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic issue(input int o, input logic [7:0] ba, output int lat, output logic e);
    @(negedge clk);
    start = 1'b1;
    op_i  = 4'(o);
    bit_i = ba;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    e   = 1'b0;
    for (int n = 1; n <= 30; n++) begin
      if (done) begin
        lat = n;
        e   = err;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic region_check(input string tag);
    int bad;
    bad = -1;
    for (int j = 0; j < 128; j++) if (mem[j] !== exp_mem[j] && bad < 0) bad = j;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, int'(mem[bad]), int'(exp_mem[bad]));
  endtask

  task automatic set_carry(input logic v);
    int lat;
    logic e;
    issue(v ? C_SETC : C_CLRC, 8'h00, lat, e);
    exp_cy = v;
    check(cy == v, "R7 carry load", int'(cy), int'(v));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int   lat;
    logic e;
    int   rd0;
    int   wr0;
    rst = 1'b1;
    start = 1'b0;
    op_i = '0;
    bit_i = '0;
    exp_cy = 1'b0;
    for (int j = 0; j < 128; j++) exp_mem[j] = pat(j);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12: reset values
    check(cy == 1'b0 && done == 1'b0 && err == 1'b0, "R12 flags",
          int'({cy, done, err}), 0);
    check(ram_rd_en == 1'b0 && ram_wr_en == 1'b0, "R12 strobes",
          int'({ram_rd_en, ram_wr_en}), 0);

    // R7/R8: carry-only operations, bit number ignored (0xFF not rejected, R10)
    rd0 = rd_cnt; wr0 = wr_cnt;
    issue(C_SETC, 8'hFF, lat, e);
    check(lat == 4 && !e, "R8 carry latency", lat, 4);
    check(cy == 1'b1, "R7 set carry", int'(cy), 1);
    issue(C_CPLC, 8'h80, lat, e);
    check(cy == 1'b0 && !e, "R7 invert carry to 0", int'(cy), 0);
    issue(C_CPLC, 8'h05, lat, e);
    check(cy == 1'b1 && lat == 4, "R7 invert carry to 1", int'(cy), 1);
    issue(C_CLRC, 8'hFF, lat, e);
    check(cy == 1'b0 && !e, "R7 clear carry", int'(cy), 0);
    check(rd_cnt == rd0 && wr_cnt == wr0, "R7 no RAM access", rd_cnt - rd0 + wr_cnt - wr0, 0);
    region_check("R7 RAM untouched");

    // Sweep every bit-level code over all 128 bit numbers
    for (int o = 0; o < 8; o++) begin
      for (int b = 0; b < 128; b++) begin
        int         a;
        int         i;
        logic       bv;
        string      tag;
        a = 32 + (b >> 3);
        i = b & 7;
        set_carry(1'(((b >> 1) ^ b ^ o) & 1));
        bv = exp_mem[a][i];
        case (o)
          C_AND:   exp_cy = exp_cy & bv;
          C_OR:    exp_cy = exp_cy | bv;
          C_XOR:   exp_cy = exp_cy ^ bv;
          C_LOAD:  exp_cy = bv;
          C_STORE: exp_mem[a][i] = exp_cy;
          C_CPLB:  exp_mem[a][i] = ~bv;
          C_SETB:  exp_mem[a][i] = 1'b1;
          default: exp_mem[a][i] = 1'b0;
        endcase
        tag = (o == C_AND) ? "R3" : (o <= C_XOR) ? "R4" : (o == C_LOAD) ? "R5" : "R6";
        rd0 = rd_cnt; wr0 = wr_cnt;
        issue(o, 8'(b), lat, e);
        check(lat == 9 && !e, "R8 bit op latency", lat, 9);
        check(cy == exp_cy, {tag, " carry result"}, int'(cy), int'(exp_cy));
        check(rd_cnt - rd0 == 1 && rd_last == a, "R1 byte address", rd_last, a);
        check(wr_cnt - wr0 == ((o >= C_STORE) ? 1 : 0), {tag, " write count"},
              wr_cnt - wr0, (o >= C_STORE) ? 1 : 0);
        @(negedge clk);
        check(!done, "R9 done single cycle", int'(done), 0);
        region_check({tag, " RAM contents"});
      end
    end

    // R10: rejected requests
    set_carry(1'b1);
    rd0 = rd_cnt; wr0 = wr_cnt;
    issue(C_SETB, 8'h80, lat, e);
    check(lat == 3 && e, "R10 range reject timing", lat, 3);
    issue(C_CLRB, 8'hC5, lat, e);
    check(lat == 3 && e, "R10 range reject CLR", lat, 3);
    issue(11, 8'h10, lat, e);
    check(lat == 3 && e, "R10 code 11 reject", lat, 3);
    issue(15, 8'h22, lat, e);
    check(lat == 3 && e, "R10 code 15 reject", lat, 3);
    check(cy == 1'b1, "R10 carry kept", int'(cy), 1);
    check(rd_cnt == rd0 && wr_cnt == wr0, "R10 no RAM access", rd_cnt - rd0 + wr_cnt - wr0, 0);
    region_check("R10 RAM untouched");
    issue(C_LOAD, 8'h7F, lat, e);
    exp_cy = exp_mem[47][7];
    check(lat == 9 && !e && cy == exp_cy, "R1 top bit number accepted", int'(cy), int'(exp_cy));

    // R11: request during busy is ignored (bit 0x40 is byte 0x28 bit 0)
    set_carry(1'b0);
    exp_mem[8'h28][0] = exp_mem[8'h28][0];
    exp_mem[32 + (8'h13 >> 3)][3] = 1'b0;
    @(negedge clk);
    start = 1'b1; op_i = 4'(C_CLRB); bit_i = 8'h13;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; op_i = 4'(C_SETB); bit_i = 8'h40;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int n = 3; n <= 30; n++) begin
      if (done) begin
        lat = n;
        break;
      end
      @(negedge clk);
    end
    check(lat == 9, "R11 first request done", lat, 9);
    rd0 = 0;
    for (int n = 0; n < 14; n++) begin
      @(negedge clk);
      if (done) rd0++;
    end
    check(rd0 == 0, "R11 no second done", rd0, 0);
    check(mem[8'h28] == exp_mem[8'h28], "R11 ignored byte unchanged",
          int'(mem[8'h28]), int'(exp_mem[8'h28]));
    region_check("R11 RAM contents");

    summary();
    $finish;
  end

endmodule